// File: doc/BRIEF.md
# Nibble-Partitioned Column Multiplier

This block multiplies two unsigned operands and returns their full double-width product. Each operand is cut into an upper and a lower nibble. Four small multiplier cores each take one nibble of each operand and build their result one column at a time. For each output weight k, a core adds every bit-product whose two indices sum to k to the carry left over from the column below. A core never adds shifted rows.

The four nibble products are then combined with exactly three adders, each offset from the others by one nibble. The low nibble of the low-by-low product goes straight to the bottom of the result. The two cross products are added together. The upper half of the low-by-low product is added to that sum. The high-by-high product, at a weight of one full operand width, is added last.

Each merging adder is a carry-skip adder. Its blocks all start from a zero carry, so they work in parallel. A chain of half adders then folds in the carry from the stage below. The carry out of a stage comes straight from the block's own carry or from the incoming carry, and does not wait for the incrementer. The arithmetic is fully combinational. An optional output register, selected by parameter, can be placed after it for timing.

Top module: `nibble_cross_mult`

## Requirements
- R1: Product bits [3:0] equal the low four bits of the product of the operands' low nibbles (opa[3:0] × opb[3:0]).
- R2: With the default parameters, `prod` equals `opa` × `opb` as unsigned integers, for all 65,536 operand pairs.
- R3: `rst_n` is an active-low asynchronous reset. While it is low, `prod` reads zero, whatever the operands.
- R4: With the output register enabled (the default), `prod` changes only at a rising clock edge. After each edge it shows the product of the operands present at that edge.
- R5: When both upper nibbles are zero, the result is the low-by-low nibble product alone. When both lower nibbles are zero, it is the high-by-high nibble product shifted up by eight.
- R6: The final merging adder never produces a carry beyond the top product bit. The largest case, 255 × 255, gives 65,025.
- R7: A zero operand gives a zero product, whatever the other operand is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opa | input | 8 | Unsigned multiplicand |
| opb | input | 8 | Unsigned multiplier |
| prod | output | 16 | Unsigned product |

## Verification
The hardest paths to reach are the long carry runs through the skip adders. The incrementer and the skip term only matter when a whole block of intermediate sum bits is ones and a carry arrives from below. A carry out of the cross-product adder and a carry out of the mid adder also have to land in the same upper window. Only a few operand pairs produce these patterns, so the bench does not search for them. It sweeps every operand pair, which covers each of these carry patterns. Directed steps then check the register timing and an asynchronous reset applied between clock edges.

// File: rtl/vc_mult_pkg.sv
package vc_mult_pkg;
   localparam int NIB_DEF  = 4;
   localparam int SKIP_DEF = 4;

   // width of the running column accumulator for an n-by-n column core
   function automatic int col_acc_w(input int n);
      return n + $clog2(n) + 2;
   endfunction
endpackage

// File: rtl/vc_rca_blk.sv
module vc_rca_blk #(
   parameter int W = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   always_comb begin
      logic c;
      c = ci;
      for (int i = 0; i < W; i++) begin
         s[i] = x[i] ^ y[i] ^ c;
         c    = (x[i] & y[i]) | (c & (x[i] ^ y[i]));
      end
      co = c;
   end
endmodule

// File: rtl/vc_skip_adder.sv
module vc_skip_adder #(
   parameter int W   = 8,
   parameter int BLK = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         ci,
   output logic [W-1:0] s,
   output logic         co
);
   localparam int NST = W / BLK;

   if (BLK < 1 || (W % BLK) != 0) begin : g_bad_blk
      $error("vc_skip_adder: W must be a multiple of BLK");
   end

   logic [NST:0] stage_c;
   assign stage_c[0] = ci;

   for (genvar g = 0; g < NST; g++) begin : g_stage
      logic [BLK-1:0] z;
      logic           blk_c;

      if (g == 0) begin : g_first
         vc_rca_blk #(.W(BLK)) u_rca (
            .x (x[BLK-1:0]),
            .y (y[BLK-1:0]),
            .ci(stage_c[0]),
            .s (z),
            .co(blk_c)
         );
         assign s[BLK-1:0]  = z;
         assign stage_c[1]  = blk_c;
      end else begin : g_rest
         // block starts from zero carry, runs in parallel with the others
         vc_rca_blk #(.W(BLK)) u_rca (
            .x (x[g*BLK +: BLK]),
            .y (y[g*BLK +: BLK]),
            .ci(1'b0),
            .s (z),
            .co(blk_c)
         );
         // half-adder chain adds the carry arriving from the stage below
         always_comb begin
            logic t;
            t = stage_c[g];
            for (int i = 0; i < BLK; i++) begin
               s[g*BLK + i] = z[i] ^ t;
               t            = z[i] & t;
            end
         end
         // skip term: own carry, or all-ones block passes the incoming carry
         assign stage_c[g+1] = blk_c | ((&z) & stage_c[g]);
      end
   end

   assign co = stage_c[NST];
endmodule

// File: rtl/vc_col_core.sv
module vc_col_core #(
   parameter int N = 4
) (
   input  logic [N-1:0]   a,
   input  logic [N-1:0]   b,
   output logic [2*N-1:0] p
);
   import vc_mult_pkg::*;
   localparam int CW = col_acc_w(N);

   always_comb begin
      logic [CW-1:0] acc;
      acc = '0;
      p   = '0;
      for (int k = 0; k < 2*N-1; k++) begin
         for (int i = 0; i < N; i++) begin
            if ((k - i) >= 0 && (k - i) < N) begin
               acc = acc + CW'(a[i] & b[k-i]);
            end
         end
         p[k] = acc[0];
         acc  = acc >> 1;
      end
      p[2*N-1] = acc[0];
   end
endmodule

// File: rtl/nibble_cross_mult.sv
module nibble_cross_mult #(
   parameter int NIB     = vc_mult_pkg::NIB_DEF,
   parameter int SKIP    = vc_mult_pkg::SKIP_DEF,
   parameter int REG_OUT = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2*NIB-1:0]  opa,
   input  logic [2*NIB-1:0]  opb,
   output logic [4*NIB-1:0]  prod
);
   localparam int OPW = 2 * NIB;
   localparam int PW  = 2 * OPW;

   if (NIB < 2) begin : g_bad_nib
      $error("nibble_cross_mult: NIB must be at least 2");
   end
   if (SKIP < 1 || (OPW % SKIP) != 0) begin : g_bad_skip
      $error("nibble_cross_mult: SKIP must divide 2*NIB");
   end
   if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
      $error("nibble_cross_mult: REG_OUT must be 0 or 1");
   end

   logic [NIB-1:0] a_lo, a_hi, b_lo, b_hi;
   assign a_lo = opa[NIB-1:0];
   assign a_hi = opa[OPW-1:NIB];
   assign b_lo = opb[NIB-1:0];
   assign b_hi = opb[OPW-1:NIB];

   logic [OPW-1:0] pp_ll, pp_lh, pp_hl, pp_hh;

   vc_col_core #(.N(NIB)) u_core_ll (.a(a_lo), .b(b_lo), .p(pp_ll));
   vc_col_core #(.N(NIB)) u_core_lh (.a(a_lo), .b(b_hi), .p(pp_lh));
   vc_col_core #(.N(NIB)) u_core_hl (.a(a_hi), .b(b_lo), .p(pp_hl));
   vc_col_core #(.N(NIB)) u_core_hh (.a(a_hi), .b(b_hi), .p(pp_hh));

   // merge 1: the two cross products
   logic [OPW-1:0] cross_s;
   logic           cross_c;
   vc_skip_adder #(.W(OPW), .BLK(SKIP)) u_add_cross (
      .x (pp_lh), .y (pp_hl), .ci(1'b0), .s(cross_s), .co(cross_c)
   );

   // merge 2: upper half of low-by-low joins the cross sum
   logic [OPW-1:0] mid_s;
   logic           mid_c;
   vc_skip_adder #(.W(OPW), .BLK(SKIP)) u_add_mid (
      .x (cross_s), .y ({{NIB{1'b0}}, pp_ll[OPW-1:NIB]}), .ci(1'b0),
      .s (mid_s), .co(mid_c)
   );

   // merge 3: high-by-high plus the upper nibble of mid and its carries
   // (cross and mid carries cannot both be set: their total stays below 2^(OPW+1))
   logic [OPW-1:0] top_s;
   logic           top_carry;
   vc_skip_adder #(.W(OPW), .BLK(SKIP)) u_add_top (
      .x (pp_hh),
      .y ({{(NIB-1){1'b0}}, cross_c | mid_c, mid_s[OPW-1:NIB]}),
      .ci(1'b0),
      .s (top_s), .co(top_carry)
   );

   logic [PW-1:0] prod_comb;
   assign prod_comb = {top_s, mid_s[NIB-1:0], pp_ll[NIB-1:0]};

   if (REG_OUT == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prod <= '0;
         else        prod <= prod_comb;
      end
   end else begin : g_comb
      assign prod = prod_comb;
   end
endmodule

// File: rtl/vc_mult_chk.sv
module vc_mult_chk #(
   parameter int NIB     = 4,
   parameter int REG_OUT = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2*NIB-1:0] opa,
   input logic [2*NIB-1:0] opb,
   input logic [4*NIB-1:0] prod,
   input logic             ovf
);
   localparam int PW = 4 * NIB;

   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ovf);

   if (REG_OUT == 1) begin : g_seq
      // R3
      reset_zero_chk: assert property (@(posedge clk)
         !rst_n |-> (prod == '0));

      // R2 R4
      full_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (prod == PW'($past(opa)) * PW'($past(opb))));

      // R1
      low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> (prod[NIB-1:0] ==
            NIB'(PW'($past(opa[NIB-1:0])) * PW'($past(opb[NIB-1:0])))));

      // R7
      zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (primed && ($past(opa) == '0 || $past(opb) == '0)) |-> (prod == '0));
   end else begin : g_comb
      // R2
      comb_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
         prod == PW'(opa) * PW'(opb));
   end
endmodule

bind nibble_cross_mult vc_mult_chk #(.NIB(NIB), .REG_OUT(REG_OUT)) u_chk (
   .clk  (clk),
   .rst_n(rst_n),
   .opa  (opa),
   .opb  (opb),
   .prod (prod),
   .ovf  (top_carry)
);

// File: tb/test_nibble_cross_mult.sv
module test_nibble_cross_mult;
   logic        clk;
   logic        rst_n;
   logic [7:0]  opa, opb;
   logic [15:0] prod;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   nibble_cross_mult i_nibble_cross_mult (
      .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .prod(prod)
   );

   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   task automatic check(input string req, input logic [15:0] act,
                        input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: prod=%0d expected=%0d (opa=%0d opb=%0d)",
                  req, act, exp, opa, opb);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      opa   = 8'd0;
      opb   = 8'd0;
      rst_n = 1'b1;
      #1 rst_n = 1'b0;
      opa = 8'd201;
      opb = 8'd77;
      repeat (3) @(negedge clk);
      // R3: output held at zero under reset
      check("R3", prod, 16'd0);
      rst_n = 1'b1;

      // exhaustive sweep, driven at negedge, checked one cycle later
      for (int a = 0; a < 256; a++) begin
         for (int b = 0; b < 256; b++) begin
            logic [15:0] exp;
            opa = 8'(a);
            opb = 8'(b);
            exp = 16'(a * b);
            @(negedge clk);
            check("R2", prod, exp);
            check("R1", {12'd0, prod[3:0]}, {12'd0, 4'((a % 16) * (b % 16))});
            if (a < 16 && b < 16)
               check("R5", prod, 16'((a % 16) * (b % 16)));
            if ((a % 16) == 0 && (b % 16) == 0)
               check("R5", prod, 16'(((a / 16) * (b / 16)) * 256));
            if (a == 0 || b == 0)
               check("R7", prod, 16'd0);
            if (a == 255 && b == 255)
               check("R6", prod, 16'd65025);
         end
      end

      // R4: output only moves at the clock edge
      opa = 8'd3; opb = 8'd5;
      @(negedge clk);
      check("R4", prod, 16'd15);
      opa = 8'd7;
      #1 check("R4", prod, 16'd15);
      @(negedge clk);
      check("R4", prod, 16'd35);

      // R3: asynchronous reset between edges
      opa = 8'd200; opb = 8'd200;
      @(negedge clk);
      check("R4", prod, 16'd40000);
      #1 rst_n = 1'b0;
      #0.5 check("R3", prod, 16'd0);
      @(negedge clk);
      check("R3", prod, 16'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R2", prod, 16'd40000);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule